// File: doc/BRIEF.md
# Grouped Event Interrupt Aggregator

This block collects up to 96 single-cycle hardware event pulses into three 32-bit sticky status words. Software sees a small word-addressed register bus. It reads the status words and retires events by writing ones back to them. Each event `n` lives in status word `n / 32` at bit `n mod 32`.

Three independent mask groups sit beside the status words. Each group keeps one 32-bit enable word per status word. A group raises its own level-sensitive interrupt line whenever some pending status bit is also enabled in that group. A single event can therefore be routed to any mix of the three lines.

Each group also has a read-only vector word. It reports the lowest-numbered pending event that the group enables. The scan covers status word 0 first, then word 1, then word 2. Interrupt line 0 is meant for the highest-priority processor input, line 1 for the middle one and line 2 for the lowest.

Top module: `evt_irq_hub`

## Requirements
- R1: After reset, every status bit and every mask bit reads 0. All vector words read 0 and `irqOut` is 0.
- R2: A high level on `evtIn[n]` at a rising clock edge sets bit `n mod 32` of status word `n / 32`. The bit is visible the next cycle and stays set until it is cleared.
- R3: A bus write to status word `b` (word addresses 0, 1, 2) clears each status bit whose write-data bit is 1. Bits written 0 keep their value.
- R4: When an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: Mask word `b` of group `g` sits at word address `4*(g+1)+b`, with `g` and `b` each in 0..2. It takes the full write data and reads back the value written.
- R6: `irqOut[g]` is 1 exactly when at least one status bit is 1 and the matching bit in group `g`'s mask word is also 1. Each group acts independently of the others.
- R7: The vector word of group `g` sits at word address `4*(g+1)+3`. It reads bit 31 = 1 and bits 6:0 = the lowest pending enabled event number (0..95), with all other bits 0. Any pending enabled event in word 0 outranks one in word 1, and word 1 outranks word 2. With nothing pending and enabled, it reads 0.
- R8: Writes to a vector word or to an unmapped address (word 3) change no state. Reads of an unmapped address return 0.
- R9: A write cycle with `busSel` low has no effect on status or mask state.

Read data is combinational from `busAddr` while `busSel` is high and `busWr` is low. `busRdata` is 0 in all other cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| evtIn | input | 96 | Event pulse inputs, one bit per event number |
| busSel | input | 1 | Bus access select |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data |
| irqOut | output | 3 | Interrupt line per mask group |

## Verification
The bench raises single events spread across all three status words and routes them to different groups. This shows that the lines are independent and that the event-to-word mapping is right. It clears status with patterns that are all zeros, all ones except the target bit, and exactly the target bit. These patterns separate write-one-to-clear from a plain overwrite. One cycle carries a collision between an event and its own clear, which tells "event wins" apart from "clear wins". Clusters of pending events in one word, plus a late event in word 0, show whether the vector follows bit order and word order rather than arrival order.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int BANK_W      = 32;
  localparam int NUM_BANKS   = 3;
  localparam int NUM_GROUPS  = 3;
  localparam int NUM_EVT     = BANK_W * NUM_BANKS;
  localparam int EVT_IDX_W   = $clog2(NUM_EVT);
  localparam int BANK_IDX_W  = $clog2(NUM_BANKS);
  localparam int GRP_IDX_W   = $clog2(NUM_GROUPS);
  localparam int SLOT_W      = 2;
  localparam int GRP_FIELD_W = $clog2(NUM_GROUPS + 1);
  localparam int ADDR_W      = SLOT_W + GRP_FIELD_W;
  localparam int VEC_SLOT    = (1 << SLOT_W) - 1;
  localparam int MASK_W      = NUM_GROUPS * NUM_EVT;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_STS  = 2'd1,
    RD_MASK = 2'd2,
    RD_VEC  = 2'd3
  } rd_kind_t;

  typedef struct packed {
    logic [NUM_BANKS-1:0]            ackStb;
    logic [NUM_GROUPS*NUM_BANKS-1:0] maskStb;
  } wr_strobe_t;

  typedef struct packed {
    rd_kind_t              rdKind;
    logic [BANK_IDX_W-1:0] rdBank;
    logic [GRP_IDX_W-1:0]  rdGroup;
  } rd_sel_t;
endpackage

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
(
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output wr_strobe_t        wrStb,
  output rd_sel_t           rdSel
);
  logic [SLOT_W-1:0]      slot;
  logic [GRP_FIELD_W-1:0] grpField;
  int                     slotI;
  int                     grpI;

  assign slot     = busAddr[SLOT_W-1:0];
  assign grpField = busAddr[ADDR_W-1:SLOT_W];

  always_comb begin
    slotI = int'(slot);
    grpI  = int'(grpField);
    wrStb = '0;
    rdSel = '0;
    rdSel.rdKind = RD_NONE;
    if (busSel) begin
      if (grpI == 0) begin
        if (slotI < NUM_BANKS) begin
          if (busWr) wrStb.ackStb[slotI] = 1'b1;
          else begin
            rdSel.rdKind = RD_STS;
            rdSel.rdBank = BANK_IDX_W'(slotI);
          end
        end
      end else if (grpI <= NUM_GROUPS) begin
        if (slotI < NUM_BANKS) begin
          if (busWr) wrStb.maskStb[(grpI - 1) * NUM_BANKS + slotI] = 1'b1;
          else begin
            rdSel.rdKind  = RD_MASK;
            rdSel.rdBank  = BANK_IDX_W'(slotI);
            rdSel.rdGroup = GRP_IDX_W'(grpI - 1);
          end
        end else if (slotI == VEC_SLOT && !busWr) begin
          rdSel.rdKind  = RD_VEC;
          rdSel.rdGroup = GRP_IDX_W'(grpI - 1);
        end
      end
    end
  end
endmodule

// File: rtl/evt_irq_regs.sv
module evt_irq_regs
  import evt_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] evtIn,
  input  wr_strobe_t         wrStb,
  input  logic [BANK_W-1:0]  wdata,
  output logic [NUM_EVT-1:0] stsFlat,
  output logic [MASK_W-1:0]  maskFlat
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sts
    logic [BANK_W-1:0] stsQ;
    logic [BANK_W-1:0] hit;
    assign hit = evtIn[b*BANK_W +: BANK_W];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                stsQ <= '0;
      else if (wrStb.ackStb[b]) stsQ <= (stsQ & ~wdata) | hit;
      else                      stsQ <= stsQ | hit;
    end
    assign stsFlat[b*BANK_W +: BANK_W] = stsQ;
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_word
      logic [BANK_W-1:0] maskQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                              maskQ <= '0;
        else if (wrStb.maskStb[g*NUM_BANKS+b]) maskQ <= wdata;
      end
      assign maskFlat[g*NUM_EVT + b*BANK_W +: BANK_W] = maskQ;
    end
  end
endmodule

// File: rtl/evt_irq_resolve.sv
module evt_irq_resolve
  import evt_irq_pkg::*;
(
  input  logic [NUM_EVT-1:0]    stsFlat,
  input  logic [MASK_W-1:0]     maskFlat,
  input  rd_sel_t               rdSel,
  output logic [NUM_GROUPS-1:0] irqOut,
  output logic [BANK_W-1:0]     rdData
);
  logic [NUM_GROUPS*BANK_W-1:0] vecFlat;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic [NUM_EVT-1:0]   pend;
    logic                 found;
    logic [EVT_IDX_W-1:0] idx;
    assign pend      = stsFlat & maskFlat[g*NUM_EVT +: NUM_EVT];
    assign irqOut[g] = |pend;
    // Downward scan: the last hit written is the lowest event number
    always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = NUM_EVT - 1; i >= 0; i--) begin
        if (pend[i]) begin
          found = 1'b1;
          idx   = EVT_IDX_W'(i);
        end
      end
    end
    assign vecFlat[g*BANK_W +: BANK_W] = {found, {(BANK_W-1-EVT_IDX_W){1'b0}}, idx};
  end

  always_comb begin
    case (rdSel.rdKind)
      RD_STS:  rdData = stsFlat[int'(rdSel.rdBank)*BANK_W +: BANK_W];
      RD_MASK: rdData = maskFlat[int'(rdSel.rdGroup)*NUM_EVT + int'(rdSel.rdBank)*BANK_W +: BANK_W];
      RD_VEC:  rdData = vecFlat[int'(rdSel.rdGroup)*BANK_W +: BANK_W];
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub
  import evt_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_EVT-1:0]    evtIn,
  input  logic                  busSel,
  input  logic                  busWr,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [BANK_W-1:0]     busWdata,
  output logic [BANK_W-1:0]     busRdata,
  output logic [NUM_GROUPS-1:0] irqOut
);
  wr_strobe_t         wrStb;
  rd_sel_t            rdSel;
  logic [NUM_EVT-1:0] stsFlat;
  logic [MASK_W-1:0]  maskFlat;

  evt_irq_ctrl u_ctrl (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .wrStb  (wrStb),
    .rdSel  (rdSel)
  );

  evt_irq_regs u_regs (
    .clk     (clk),
    .rstN    (rstN),
    .evtIn   (evtIn),
    .wrStb   (wrStb),
    .wdata   (busWdata),
    .stsFlat (stsFlat),
    .maskFlat(maskFlat)
  );

  evt_irq_resolve u_resolve (
    .stsFlat (stsFlat),
    .maskFlat(maskFlat),
    .rdSel   (rdSel),
    .irqOut  (irqOut),
    .rdData  (busRdata)
  );
endmodule

// File: rtl/evt_irq_checker.sv
module evt_irq_checker
  import evt_irq_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  busSel,
  input logic                  busWr,
  input logic [NUM_EVT-1:0]    evtIn,
  input logic [NUM_EVT-1:0]    stsFlat,
  input logic [MASK_W-1:0]     maskFlat,
  input logic [NUM_GROUPS-1:0] irqOut
);
  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (stsFlat == '0 && maskFlat == '0));

  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    (evtIn != '0) |=> ((stsFlat & $past(evtIn)) == $past(evtIn)));

  p_status_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && busWr) |=> ((stsFlat & $past(stsFlat)) == $past(stsFlat)));

  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && busWr) |=> $stable(maskFlat));

  p_irq_needs_pending_r6: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut != '0) |-> (stsFlat != '0));

  p_irq_needs_mask_r6: assert property (@(posedge clk) disable iff (!rstN)
    (maskFlat == '0) |-> (irqOut == '0));
endmodule

bind evt_irq_hub evt_irq_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busSel  (busSel),
  .busWr   (busWr),
  .evtIn   (evtIn),
  .stsFlat (stsFlat),
  .maskFlat(maskFlat),
  .irqOut  (irqOut)
);

// File: tb/evt_irq_hub_bench.sv
module evt_irq_hub_bench;
  import evt_irq_pkg::*;

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic [NUM_EVT-1:0]    evtIn = '0;
  logic                  busSel = 1'b0;
  logic                  busWr = 1'b0;
  logic [ADDR_W-1:0]     busAddr = '0;
  logic [BANK_W-1:0]     busWdata = '0;
  logic [BANK_W-1:0]     busRdata;
  logic [NUM_GROUPS-1:0] irqOut;

  evt_irq_hub u_evt_irq_hub (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  always #4 clk = ~clk;

  typedef struct {
    logic [31:0] exp;
    int          kind;
    string       tag;
  } item_t;

  item_t sbq[$];
  int    probe = 0;
  int    compared = 0;
  int    mismatched = 0;
  bit    done = 1'b0;

  function automatic logic [NUM_EVT-1:0] ev(input int n);
    return NUM_EVT'(1) << n;
  endfunction

  task automatic rdChk(input int a, input logic [31:0] e, input string tag);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = ADDR_W'(a);
    sbq.push_back('{e, 1, tag});
    probe = 1;
    #5 probe = 0; busSel = 1'b0;
  endtask

  task automatic irqChk(input logic [2:0] e, input string tag);
    @(negedge clk);
    sbq.push_back('{{29'd0, e}, 2, tag});
    probe = 2;
    #5 probe = 0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = ADDR_W'(a); busWdata = d;
    @(posedge clk); #1;
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic pulse(input logic [NUM_EVT-1:0] v);
    @(negedge clk);
    evtIn = v;
    @(posedge clk); #1;
    evtIn = '0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  // Monitor: pops expected items and compares them between clock edges
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (probe != 0) begin
        logic [31:0] act;
        item_t it;
        if (sbq.size() == 0) begin
          mismatched++;
          $display("FAIL scoreboard empty actual=none expected=item");
        end else begin
          it  = sbq.pop_front();
          act = (it.kind == 1) ? busRdata : {29'd0, irqOut};
          compared++;
          if (act !== it.exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
          end
        end
      end
    end
  end

  initial begin
    #(8 * 50000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog all-reqs actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: everything zero after reset
    for (int w = 0; w < 16; w++) rdChk(w, 32'h0, "R1 reset read");
    irqChk(3'b000, "R1 reset irq");

    // R5: mask write and readback, then clear
    for (int g = 0; g < 3; g++)
      for (int b = 0; b < 3; b++) wr(4*(g+1)+b, 32'h1111_1111 * (g*3+b+1));
    for (int g = 0; g < 3; g++)
      for (int b = 0; b < 3; b++) rdChk(4*(g+1)+b, 32'h1111_1111 * (g*3+b+1), "R5 mask readback");
    for (int g = 0; g < 3; g++)
      for (int b = 0; b < 3; b++) wr(4*(g+1)+b, 32'h0);

    // R2: events in each word
    pulse(ev(3) | ev(40) | ev(95));
    rdChk(0, 32'h0000_0008, "R2 word0");
    rdChk(1, 32'h0000_0100, "R2 word1");
    rdChk(2, 32'h8000_0000, "R2 word2");
    irqChk(3'b000, "R6 all masked");
    rdChk(7, 32'h0, "R7 vec0 idle");
    rdChk(11, 32'h0, "R7 vec1 idle");
    rdChk(15, 32'h0, "R7 vec2 idle");

    // R6 / R7: route events to groups
    wr(9, 32'h0000_0100);
    irqChk(3'b010, "R6 group1 only");
    rdChk(11, 32'h8000_0028, "R7 vec1 event40");
    wr(14, 32'h8000_0000);
    irqChk(3'b110, "R6 groups 1 and 2");
    rdChk(15, 32'h8000_005F, "R7 vec2 event95");
    wr(12, 32'h0000_0008);
    rdChk(15, 32'h8000_0003, "R7 vec2 word0 first");

    // R3: write-one-to-clear
    wr(0, 32'h0);
    rdChk(0, 32'h0000_0008, "R3 zero write keeps");
    wr(0, 32'hFFFF_FFF7);
    rdChk(0, 32'h0000_0008, "R3 other ones keep");
    wr(0, 32'h0000_0008);
    rdChk(0, 32'h0, "R3 target cleared");
    rdChk(15, 32'h8000_005F, "R7 vec2 after clear");
    irqChk(3'b110, "R6 after clear");

    // R4: event and clear of same bit in one cycle
    @(negedge clk);
    evtIn = ev(40); busSel = 1'b1; busWr = 1'b1; busAddr = 4'd1; busWdata = 32'h0000_0100;
    @(posedge clk); #1;
    evtIn = '0; busSel = 1'b0; busWr = 1'b0;
    rdChk(1, 32'h0000_0100, "R4 event wins");
    wr(1, 32'h0000_0100);
    rdChk(1, 32'h0, "R3 clear after collision");
    irqChk(3'b100, "R6 group2 only");
    rdChk(11, 32'h0, "R7 vec1 empty");

    // R8: writes to vector and unmapped words ignored
    wr(15, 32'hFFFF_FFFF);
    wr(7, 32'hFFFF_FFFF);
    wr(3, 32'hFFFF_FFFF);
    rdChk(15, 32'h8000_005F, "R8 vec write ignored");
    rdChk(3, 32'h0, "R8 unmapped read");
    rdChk(2, 32'h8000_0000, "R8 status untouched");
    rdChk(4, 32'h0, "R8 mask untouched");

    // R9: deselected write ignored
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b1; busAddr = 4'd4; busWdata = 32'hFFFF_FFFF;
    @(posedge clk); #1;
    busAddr = 4'd2;
    @(posedge clk); #1;
    busWr = 1'b0;
    rdChk(4, 32'h0, "R9 mask unchanged");
    rdChk(2, 32'h8000_0000, "R9 status unchanged");

    // R7: lowest bit and word order for a cluster
    wr(10, 32'hFFFF_FFFF);
    pulse(ev(70) | ev(64) | ev(66));
    rdChk(2, 32'h8000_0045, "R2 cluster word2");
    rdChk(11, 32'h8000_0040, "R7 vec1 lowest 64");
    irqChk(3'b110, "R6 group1 via word2");
    wr(2, 32'h0000_0001);
    rdChk(11, 32'h8000_0042, "R7 vec1 next 66");
    wr(8, 32'h8000_0000);
    pulse(ev(31));
    rdChk(11, 32'h8000_001F, "R7 vec1 word0 outranks");

    repeat (3) @(posedge clk);
    if (sbq.size() != 0) begin
      mismatched++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", sbq.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule